// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block watches the three clocks that drive a slave serial audio port: the master clock, the bit clock and the frame clock. It measures them against a free-running local reference clock. Each clock is brought into the reference domain through a two-stage synchroniser with a rising-edge detector. One frame runs from one frame-clock rise to the next. For each frame the block counts the reference cycles it spans and the master-clock and bit-clock rises that fall inside it.

At the end of each frame the block classifies the measurement. The frame length gives the sample-rate class, and the two edge counts give the master-clock ratio and the bit-clock ratio. The frame is then checked against the legal combinations. A state machine tracks the results and reports lock once the same good classification has repeated for several frames. It raises a one-cycle error pulse for a bad frame, for a frame clock that has gone silent, and for a master clock that has stopped. The rate class can also be set from a configuration value. This happens when automatic detection is turned off, and it is forced when the AM-avoidance mode or the de-emphasis mode is on.

The state machine has three states. SEEK waits for the first frame-clock rise. TRAIN counts consecutive identical good frames. HELD is the locked state. The transitions are:
- SEEK→TRAIN on the first frame edge.
- TRAIN→TRAIN on a good frame, either advancing the count or restarting it with a new candidate.
- TRAIN→HELD when the count reaches LOCK_FRAMES.
- HELD→HELD on a repeated classification.
- HELD→TRAIN on a changed classification, a bad frame or an idle master-clock frame.
- TRAIN/HELD→SEEK on a frame timeout.

Top module: `aclk_ratio_det`

## Requirements
- R1: The rate class is chosen from the frame length in reference cycles, with these codes: quad speed is 3 when the length is at most QUAD_MAX. Double speed is 2 when it is at most DOUBLE_MAX. Normal speed is 1 when it is at most NORMAL_MAX. The 32 kHz class is 0 above NORMAL_MAX.
- R2: A master-clock count within TOL of 64, 128, 192, 256, 384 or 512 is reported on `mclk_ratio_o` as code 0, 1, 2, 3, 4 or 5 respectively. Code 7 means no ratio and is the reset value.
- R3: A 64x master clock is legal only when the effective rate class is quad speed (3). Otherwise the frame is bad.
- R4: A bit-clock count within TOL of 64 gives `sclk_ratio_o`=0, and one within TOL of 48 gives 1. Any other count is bad. The 48x ratio is legal only with master-clock code 2 (192x) or 4 (384x).
- R5: `locked_o` rises right after the frame edge that closes the LOCK_FRAMES-th consecutive good frame with the same classification. While lock holds, the classification outputs do not change.
- R6: A bad frame, that is a wrong length, an unknown ratio or an illegal pairing, gives a one-cycle pulse on `err_o` and drops lock in the same cycle.
- R7: When `auto_en_i` is 0, `rate_class_o` and the legality rules use `cfg_rate_i` instead of the measured class.
- R8: When `am_avoid_i` or `deemph_i` is 1, the rate class comes from `cfg_rate_i` even with `auto_en_i` at 1.
- R9: The first frame with no master-clock edge drops lock without an error pulse. The second consecutive such frame pulses `err_o`.
- R10: If no frame edge arrives within FRAME_MAX reference cycles, `err_o` pulses and the state returns to SEEK. A frame shorter than MIN_FRAME is bad.
- R11: During and just after reset, `locked_o`=0, `err_o`=0 and `mclk_ratio_o`=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running local reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Master clock, asynchronous |
| sclk_i | input | 1 | Bit clock, asynchronous |
| lrclk_i | input | 1 | Frame clock, asynchronous |
| auto_en_i | input | 1 | 1: rate class measured; 0: taken from cfg_rate_i |
| cfg_rate_i | input | 2 | Configured rate class code |
| am_avoid_i | input | 1 | AM-avoidance mode on; forces configured class |
| deemph_i | input | 1 | De-emphasis on; forces configured class |
| rate_class_o | output | 2 | Rate class code of current candidate |
| mclk_ratio_o | output | 3 | Master-clock ratio code |
| sclk_ratio_o | output | 1 | 0: 64x bit clock; 1: 48x |
| locked_o | output | 1 | Classification stable for LOCK_FRAMES frames |
| err_o | output | 1 | One-cycle clock error pulse |

## Verification
The bench sets the frame windows to MIN_FRAME=500, QUAD_MAX=900, DOUBLE_MAX=1700, NORMAL_MAX=3300 and FRAME_MAX=4500, with TOL=1 and LOCK_FRAMES=4. With these values every rate class and every master-clock ratio, including 512x in the 32 kHz class, can be reached with master-clock periods of only 4 to 48 reference cycles. A frame-clock timeout and a too-short frame then each occur within a few thousand cycles. The master clock can be stopped exactly on a frame boundary, so the idle-frame rule is seen separately for the first and the second silent frame.

// File: rtl/aclk_det_pkg.sv
package aclk_det_pkg;

    typedef enum logic [1:0] {
        RC_32K    = 2'd0,
        RC_NORMAL = 2'd1,
        RC_DOUBLE = 2'd2,
        RC_QUAD   = 2'd3
    } rate_class_e;

    localparam int unsigned NUM_MRATIO = 6;
    localparam logic [2:0]  MR_NONE    = 3'd7;
    localparam logic [2:0]  MR_X64     = 3'd0;
    localparam logic [2:0]  MR_X192    = 3'd2;
    localparam logic [2:0]  MR_X384    = 3'd4;

    // master-clock multiple for each ratio code
    function automatic int unsigned mratio_value(input int unsigned code);
        case (code)
            0:       return 64;
            1:       return 128;
            2:       return 192;
            3:       return 256;
            4:       return 384;
            5:       return 512;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/aclk_edge_sync.sv
module aclk_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    // STAGES synchroniser flops plus one history flop
    logic [STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], async_i};
    end

    assign rise_o = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/aclk_frame_meter.sv
module aclk_frame_meter #(
    parameter int unsigned FRAME_MAX = 7000,
    parameter int unsigned CW        = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lr_rise,
    input  logic          mclk_rise,
    input  logic          sclk_rise,
    output logic [CW-1:0] frame_len,
    output logic [CW-1:0] mclk_cnt,
    output logic [CW-1:0] sclk_cnt,
    output logic          timeout_o
);
    assign timeout_o = (frame_len == CW'(FRAME_MAX)) && !lr_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_len <= '0;
            mclk_cnt  <= '0;
            sclk_cnt  <= '0;
        end else if (lr_rise) begin
            frame_len <= CW'(1);
            mclk_cnt  <= CW'(mclk_rise);
            sclk_cnt  <= CW'(sclk_rise);
        end else if (timeout_o) begin
            frame_len <= CW'(1);
            mclk_cnt  <= '0;
            sclk_cnt  <= '0;
        end else begin
            frame_len <= frame_len + CW'(1);
            mclk_cnt  <= mclk_cnt + CW'(mclk_rise);
            sclk_cnt  <= sclk_cnt + CW'(sclk_rise);
        end
    end

    // R10: the frame counter never runs past its timeout limit
    a_r10_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        frame_len <= CW'(FRAME_MAX));
endmodule

// File: rtl/aclk_ratio_classify.sv
module aclk_ratio_classify
    import aclk_det_pkg::*;
#(
    parameter int unsigned MIN_FRAME  = 800,
    parameter int unsigned QUAD_MAX   = 1400,
    parameter int unsigned DOUBLE_MAX = 2800,
    parameter int unsigned NORMAL_MAX = 5400,
    parameter int unsigned FRAME_MAX  = 7000,
    parameter int unsigned TOL        = 1,
    parameter int unsigned CW         = 13
) (
    input  logic [CW-1:0] frame_len,
    input  logic [CW-1:0] mclk_cnt,
    input  logic [CW-1:0] sclk_cnt,
    input  logic          auto_en,
    input  logic [1:0]    cfg_rate,
    input  logic          am_avoid,
    input  logic          deemph,
    output rate_class_e   cls,
    output logic [2:0]    mratio,
    output logic          sratio,
    output logic          good,
    output logic          mclk_idle
);
    int unsigned flen, mcnt, scnt;
    rate_class_e meas_cls;
    logic        len_ok, m_hit, s_hit, pair_ok;

    always_comb begin
        flen = 32'(frame_len);
        mcnt = 32'(mclk_cnt);
        scnt = 32'(sclk_cnt);

        // R1: frame-length windows
        if (flen <= QUAD_MAX)        meas_cls = RC_QUAD;
        else if (flen <= DOUBLE_MAX) meas_cls = RC_DOUBLE;
        else if (flen <= NORMAL_MAX) meas_cls = RC_NORMAL;
        else                         meas_cls = RC_32K;
        len_ok = (flen >= MIN_FRAME) && (flen <= FRAME_MAX);

        // R7 / R8: configured class overrides measurement
        if (!auto_en || am_avoid || deemph) cls = rate_class_e'(cfg_rate);
        else                                cls = meas_cls;

        // R2: master-clock ratio match
        mratio = MR_NONE;
        m_hit  = 1'b0;
        for (int unsigned i = 0; i < NUM_MRATIO; i++) begin
            if ((mcnt + TOL >= mratio_value(i)) && (mcnt <= mratio_value(i) + TOL)) begin
                mratio = 3'(i);
                m_hit  = 1'b1;
            end
        end

        // R4: bit-clock ratio match
        sratio = 1'b0;
        s_hit  = 1'b0;
        if ((scnt + TOL >= 64) && (scnt <= 64 + TOL)) begin
            s_hit = 1'b1;
        end else if ((scnt + TOL >= 48) && (scnt <= 48 + TOL)) begin
            s_hit  = 1'b1;
            sratio = 1'b1;
        end

        // R3 / R4: legal pairings
        pair_ok = !((mratio == MR_X64) && (cls != RC_QUAD)) &&
                  !(sratio && (mratio != MR_X192) && (mratio != MR_X384));

        mclk_idle = (mcnt == 0);
        good      = len_ok && m_hit && s_hit && pair_ok;
    end
endmodule

// File: rtl/aclk_ratio_det.sv
module aclk_ratio_det
    import aclk_det_pkg::*;
#(
    parameter int unsigned MIN_FRAME   = 800,
    parameter int unsigned QUAD_MAX    = 1400,
    parameter int unsigned DOUBLE_MAX  = 2800,
    parameter int unsigned NORMAL_MAX  = 5400,
    parameter int unsigned FRAME_MAX   = 7000,
    parameter int unsigned TOL         = 1,
    parameter int unsigned LOCK_FRAMES = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       mclk_i,
    input  logic       sclk_i,
    input  logic       lrclk_i,
    input  logic       auto_en_i,
    input  logic [1:0] cfg_rate_i,
    input  logic       am_avoid_i,
    input  logic       deemph_i,
    output logic [1:0] rate_class_o,
    output logic [2:0] mclk_ratio_o,
    output logic       sclk_ratio_o,
    output logic       locked_o,
    output logic       err_o
);
    localparam int unsigned CW = $clog2(FRAME_MAX + 1);
    localparam int unsigned LW = $clog2(LOCK_FRAMES + 1);

    typedef enum logic [1:0] {ST_SEEK, ST_TRAIN, ST_HELD} det_state_e;

    // clock edge detection in the reference domain
    logic [2:0] raw_clk, clk_rise;
    assign raw_clk = {lrclk_i, sclk_i, mclk_i};

    for (genvar g = 0; g < 3; g++) begin : g_sync
        aclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk_ref), .rst_n(rst_n), .async_i(raw_clk[g]), .rise_o(clk_rise[g])
        );
    end

    logic          lr_rise, timeout;
    logic [CW-1:0] frame_len, mclk_cnt, sclk_cnt;
    assign lr_rise = clk_rise[2];

    aclk_frame_meter #(.FRAME_MAX(FRAME_MAX), .CW(CW)) u_meter (
        .clk(clk_ref), .rst_n(rst_n), .lr_rise(lr_rise),
        .mclk_rise(clk_rise[0]), .sclk_rise(clk_rise[1]),
        .frame_len(frame_len), .mclk_cnt(mclk_cnt), .sclk_cnt(sclk_cnt),
        .timeout_o(timeout)
    );

    rate_class_e new_cls;
    logic [2:0]  new_mr;
    logic        new_sr, new_good, new_idle;

    aclk_ratio_classify #(
        .MIN_FRAME(MIN_FRAME), .QUAD_MAX(QUAD_MAX), .DOUBLE_MAX(DOUBLE_MAX),
        .NORMAL_MAX(NORMAL_MAX), .FRAME_MAX(FRAME_MAX), .TOL(TOL), .CW(CW)
    ) u_class (
        .frame_len(frame_len), .mclk_cnt(mclk_cnt), .sclk_cnt(sclk_cnt),
        .auto_en(auto_en_i), .cfg_rate(cfg_rate_i), .am_avoid(am_avoid_i),
        .deemph(deemph_i), .cls(new_cls), .mratio(new_mr), .sratio(new_sr),
        .good(new_good), .mclk_idle(new_idle)
    );

    // candidate, counters and state
    det_state_e  state_q, state_d;
    logic [LW-1:0] cnt_q, cnt_d;
    rate_class_e cand_cls_q;
    logic [2:0]  cand_mr_q;
    logic        cand_sr_q, idle_q, idle_d, err_q, err_d, load_cand, same;

    assign same = (cnt_q != '0) && (new_cls == cand_cls_q) &&
                  (new_mr == cand_mr_q) && (new_sr == cand_sr_q);

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        idle_d    = idle_q;
        err_d     = 1'b0;
        load_cand = 1'b0;
        unique case (state_q)
            ST_SEEK: begin
                cnt_d  = '0;
                idle_d = 1'b0;
                if (timeout) err_d = 1'b1;                 // R10
                else if (lr_rise) state_d = ST_TRAIN;
            end
            ST_TRAIN, ST_HELD: begin
                if (timeout) begin                          // R10
                    state_d = ST_SEEK;
                    cnt_d   = '0;
                    idle_d  = 1'b0;
                    err_d   = 1'b1;
                end else if (lr_rise) begin
                    if (new_good) begin
                        idle_d = 1'b0;
                        if (same) begin
                            if (cnt_q != LW'(LOCK_FRAMES)) cnt_d = cnt_q + LW'(1);
                        end else begin
                            load_cand = 1'b1;
                            cnt_d     = LW'(1);
                        end
                        state_d = (cnt_d == LW'(LOCK_FRAMES)) ? ST_HELD : ST_TRAIN; // R5
                    end else if (new_idle) begin            // R9
                        state_d = ST_TRAIN;
                        cnt_d   = '0;
                        err_d   = idle_q;
                        idle_d  = 1'b1;
                    end else begin                          // R6
                        state_d = ST_TRAIN;
                        cnt_d   = '0;
                        idle_d  = 1'b0;
                        err_d   = 1'b1;
                    end
                end
            end
            default: state_d = ST_SEEK;
        endcase
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_SEEK;
            cnt_q      <= '0;
            idle_q     <= 1'b0;
            err_q      <= 1'b0;
            cand_cls_q <= RC_32K;
            cand_mr_q  <= MR_NONE;
            cand_sr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idle_q  <= idle_d;
            err_q   <= err_d;
            if (load_cand) begin
                cand_cls_q <= new_cls;
                cand_mr_q  <= new_mr;
                cand_sr_q  <= new_sr;
            end
        end
    end

    always_comb begin
        locked_o     = (state_q == ST_HELD);
        err_o        = err_q;
        rate_class_o = cand_cls_q;
        mclk_ratio_o = cand_mr_q;
        sclk_ratio_o = cand_sr_q;
    end

    a_r6_err_unlocks: assert property (@(posedge clk_ref) disable iff (!rst_n)
        err_o |-> !locked_o);
    a_r6_err_one_cycle: assert property (@(posedge clk_ref) disable iff (!rst_n)
        err_o |=> !err_o);
    a_r5_lock_on_frame_edge: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(locked_o) |-> $past(lr_rise));
    a_r5_lock_holds_class: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (locked_o && $past(locked_o)) |-> ($stable(rate_class_o) && $stable(mclk_ratio_o)
                                           && $stable(sclk_ratio_o)));
    a_r3_x64_quad_only: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (locked_o && mclk_ratio_o == MR_X64) |-> (rate_class_o == RC_QUAD));
    a_r4_x48_pairing: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (locked_o && sclk_ratio_o) |-> (mclk_ratio_o == MR_X192 || mclk_ratio_o == MR_X384));
endmodule

// File: tb/sim_aclk_ratio_det.sv
`timescale 1ns/1ps
module sim_aclk_ratio_det;
    typedef struct {
        bit       is_err;
        bit [1:0] cls;
        bit [2:0] mr;
        bit       sr;
        int       frames;
        string    req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk = 1'b0, sclk = 1'b0, lrclk = 1'b0;
    logic auto_en = 1'b1, am = 1'b0, de = 1'b0;
    logic [1:0] cfg_rate = 2'd0;
    logic [1:0] rate_class;
    logic [2:0] mclk_ratio;
    logic sclk_ratio, locked, err;

    int total = 0, bad = 0, err_seen = 0;
    bit done = 0;
    exp_t q[$];

    // generator controls
    bit gen_run = 0, mclk_on_req = 1, mclk_on = 1;
    int mh = 6, sh = 24, ratio = 256, t = 0, frames = 0;

    always #2.5 clk = ~clk;

    aclk_ratio_det #(
        .MIN_FRAME(500), .QUAD_MAX(900), .DOUBLE_MAX(1700), .NORMAL_MAX(3300),
        .FRAME_MAX(4500), .TOL(1), .LOCK_FRAMES(4), .SYNC_STAGES(2)
    ) u0 (
        .clk_ref(clk), .rst_n(rst_n), .mclk_i(mclk), .sclk_i(sclk), .lrclk_i(lrclk),
        .auto_en_i(auto_en), .cfg_rate_i(cfg_rate), .am_avoid_i(am), .deemph_i(de),
        .rate_class_o(rate_class), .mclk_ratio_o(mclk_ratio), .sclk_ratio_o(sclk_ratio),
        .locked_o(locked), .err_o(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // clock generator: coherent clocks, frame edge at t==0
    initial begin
        forever begin
            @(negedge clk);
            if (!gen_run) begin
                t = 0; frames = 0; mclk = 0; sclk = 0; lrclk = 0;
            end else begin
                if (t == 0) begin
                    mclk_on = mclk_on_req;
                    frames++;
                end
                mclk  = mclk_on && ((t % (2*mh)) < mh);
                sclk  = (t % (2*sh)) < sh;
                lrclk = t < ratio*mh;
                t = (t + 1 == ratio*2*mh) ? 0 : t + 1;
            end
        end
    end

    // monitor: pops expected items on lock rise or error pulse
    initial begin
        bit prev_lock = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                bit ev_lock;
                ev_lock = locked && !prev_lock;
                if (err) err_seen++;
                if ((ev_lock || err) && q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.is_err) begin
                        chk(err == 1'b1, {e.req, " error pulse"}, int'(err), 1);
                    end else begin
                        chk(ev_lock && !err, {e.req, " lock event"}, int'(err), 0);
                        chk(rate_class == e.cls, {e.req, " R1 rate class"}, rate_class, e.cls);
                        chk(mclk_ratio == e.mr, {e.req, " R2 mclk ratio"}, mclk_ratio, e.mr);
                        chk(sclk_ratio == e.sr, {e.req, " R4 sclk ratio"}, sclk_ratio, e.sr);
                        chk(frames == e.frames, {e.req, " R5 frames to lock"}, frames, e.frames);
                    end
                end
                prev_lock = locked;
            end else begin
                prev_lock = 0;
            end
        end
    end

    task automatic run_case(input string req, input int mh_, input int sh_, input int ratio_,
                            input bit auto_, input bit [1:0] cfg_, input bit am_, input bit de_,
                            input exp_t e, input int limit);
        @(negedge clk);
        rst_n = 0; gen_run = 0; mclk_on_req = 1;
        mh = mh_; sh = sh_; ratio = ratio_;
        auto_en = auto_; cfg_rate = cfg_; am = am_; de = de_;
        e.req = req;
        q.push_back(e);
        repeat (4) @(negedge clk);
        err_seen = 0;
        rst_n = 1; gen_run = 1;
        for (int i = 0; i < limit && q.size() > 0; i++) @(negedge clk);
        chk(q.size() == 0, {req, " expected event seen"}, q.size(), 0);
        if (q.size() > 0) void'(q.pop_front());
        if (!e.is_err) chk(err_seen == 0, {req, " R6 no spurious error"}, err_seen, 0);
    endtask

    function automatic exp_t lk(input bit [1:0] c, input bit [2:0] m, input bit s);
        exp_t e;
        e.is_err = 0; e.cls = c; e.mr = m; e.sr = s; e.frames = 5; e.req = "";
        return e;
    endfunction

    function automatic exp_t er();
        exp_t e;
        e.is_err = 1; e.cls = 0; e.mr = 0; e.sr = 0; e.frames = 0; e.req = "";
        return e;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(locked == 0, "R11 locked in reset", locked, 0);
        chk(err == 0, "R11 err in reset", err, 0);
        chk(mclk_ratio == 3'd7, "R11 ratio in reset", mclk_ratio, 7);

        run_case("R1 normal 256x", 6, 24, 256, 1, 0, 0, 0, lk(2'd1, 3'd3, 0), 30000);
        run_case("R1 double 384x/48x", 2, 16, 384, 1, 0, 0, 0, lk(2'd2, 3'd4, 1), 20000);
        run_case("R4 double 192x/48x", 4, 16, 192, 1, 0, 0, 0, lk(2'd2, 3'd2, 1), 20000);
        run_case("R1 32k 512x", 4, 32, 512, 1, 0, 0, 0, lk(2'd0, 3'd5, 0), 40000);
        run_case("R3 quad 64x", 6, 6, 64, 1, 0, 0, 0, lk(2'd3, 3'd0, 0), 10000);

        // R9: stop master clock on a frame boundary after lock
        err_seen = 0;
        mclk_on_req = 0;
        for (int i = 0; i < 3000 && locked; i++) @(negedge clk);
        chk(locked == 0, "R9 lock dropped on idle frame", locked, 0);
        chk(err_seen == 0, "R9 no error on first idle frame", err_seen, 0);
        begin
            exp_t e;
            e = er(); e.req = "R9 second idle frame";
            q.push_back(e);
        end
        for (int i = 0; i < 2000 && q.size() > 0; i++) @(negedge clk);
        chk(q.size() == 0, "R9 error on second idle frame", q.size(), 0);
        if (q.size() > 0) void'(q.pop_front());

        run_case("R3 64x at normal rate", 24, 24, 64, 1, 0, 0, 0, er(), 10000);
        run_case("R4 48x with 256x", 6, 32, 256, 1, 0, 0, 0, er(), 10000);
        run_case("R7 auto off", 6, 24, 256, 0, 2'd2, 0, 0, lk(2'd2, 3'd3, 0), 30000);
        run_case("R8 de-emphasis forces class", 6, 24, 256, 1, 2'd3, 0, 1, lk(2'd3, 3'd3, 0), 30000);
        run_case("R8 AM avoid forces class", 6, 6, 64, 1, 2'd0, 1, 0, er(), 5000);
        run_case("R10 short frame", 2, 2, 64, 1, 0, 0, 0, er(), 3000);
        run_case("R10 frame timeout", 6, 48, 512, 1, 0, 0, 0, er(), 8000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule